// File: doc/BRIEF.md
# Output Fault Protection Controller

This block watches a regulator's output and decides when the power stage must stop switching. It compares a digital feedback code with a reference code and applies three voltage rules. It also takes a thermal-trip flag and a valley over-current flag. When a fault is confirmed, it drives one command that turns both power switches off.

Each fault is handled differently. An over-voltage condition needs a run of consecutive confirmation cycles before it trips. It releases by itself once feedback drops under a lower threshold. An under-voltage condition has a longer confirmation window with a re-arm band. Once it trips, the block holds the stage off for a hiccup period of seven soft-start lengths and then sends a one-cycle request for a new soft start. Thermal shutdown follows its flag without latching. The over-current flag does not stop the stage. Instead it asks for the low-side switch to stay on, which also holds back new on-pulses. An input from the soft-start sequencer masks under-voltage detection while the output is still ramping.

Top module: `fault_guard`

## Requirements
- R1: Over-voltage status (statusBits[0]) and switchesOff rise at the OV_CONFIRM-th consecutive rising edge on which fbCode*4 > refCode*5. Feedback equal to exactly 125% of the reference, or any break in the run, restarts the count.
- R2: Once set, over-voltage status stays set while fbCode*5 >= refCode*6. It clears one edge after feedback goes below 120% of the reference, with no restart request.
- R3: Under-voltage status (statusBits[1]) sets at the UV_CONFIRM-th counting edge. Counting starts when fbCode*5 < refCode*3. It continues while feedback stays below 65% (fbCode*20 < refCode*13). Reaching 65% or more before expiry clears the count.
- R4: After an under-voltage trip, statusBits[1] and switchesOff stay high for exactly HICCUP_PERIODS*SS_CYCLES cycles. On the next edge the status clears and restartReq is high for exactly one cycle.
- R5: statusBits[2] equals thermTrip delayed by one cycle and forces switchesOff. It does not latch.
- R6: statusBits[3] equals valleyOc delayed by one cycle. holdLowSide is that delayed flag gated off while switchesOff is high.
- R7: switchesOff is high exactly when any of the over-voltage, under-voltage or thermal status bits is high. Each status bit reports its own fault regardless of the others.
- R8: While ssBusy is high, under-voltage detection is disabled and its count is cleared. Low feedback for any length of time during soft start does not trip it.
- R9: During and right after reset, statusBits is 0 and switchesOff, holdLowSide and restartReq are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fbCode | input | FB_W | Sampled feedback code |
| refCode | input | FB_W | Regulation reference code |
| thermTrip | input | 1 | Die over-temperature flag, hysteresis applied upstream |
| valleyOc | input | 1 | Valley current above limit |
| ssBusy | input | 1 | Soft start in progress |
| switchesOff | output | 1 | Turn both power switches off |
| restartReq | output | 1 | One-cycle request for a fresh soft start |
| holdLowSide | output | 1 | Keep low side on and block new on-pulses |
| statusBits | output | 4 | [0] over-voltage, [1] under-voltage, [2] thermal, [3] over-current |

## Verification
The hardest states to reach are the edges of the under-voltage timer. These are the band between 60% and 65%, where the count must continue, and the exact end of the hiccup window. Feedback has to be held low for an exact number of cycles, so the stimulus splits that run between a code below 60% and a code inside the band. It then checks one cycle before and at the expected trip edge. A separate run reaches 65% for a single cycle to show that the count restarts. After a trip, the bench counts the hiccup length exactly, then raises ssBusy with feedback still low, to show that the restart does not trip again.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  // Strobes from control to datapath counters
  typedef struct packed {
    logic ovCntEn;
    logic ovCntClr;
    logic uvCntEn;
    logic uvCntClr;
    logic hicCntEn;
    logic hicCntClr;
  } strobe_t;

  // Compare results and counter terminal flags back to control
  typedef struct packed {
    logic ovAbove;
    logic ovBelowRel;
    logic uvBelow;
    logic uvRecov;
    logic ovDone;
    logic uvDone;
    logic hicDone;
  } flag_t;

  typedef enum logic {ST_RUN = 1'b0, ST_HICCUP = 1'b1} guard_state_t;

  localparam int STAT_OV = 0;
  localparam int STAT_UV = 1;
  localparam int STAT_OT = 2;
  localparam int STAT_OC = 3;

endpackage

// File: rtl/fault_guard_cnt.sv
module fault_guard_cnt #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic clr,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || clr) cnt <= '0;
    else if (en)      cnt <= cnt + 1'b1;
  end

  // Terminal: this enabled edge is the LIMIT-th
  assign done = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/fault_guard_dp.sv
module fault_guard_dp
  import fault_guard_pkg::*;
#(
  parameter int FB_W       = 10,
  parameter int OV_CONFIRM = 32,
  parameter int UV_CONFIRM = 256,
  parameter int HICCUP_LEN = 448
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [FB_W-1:0] fbCode,
  input  logic [FB_W-1:0] refCode,
  input  strobe_t         strobes,
  output flag_t           flags
);
  localparam int XW = FB_W + 5;

  logic [XW-1:0] fbX, refX;
  assign fbX  = XW'(fbCode);
  assign refX = XW'(refCode);

  // Ratio compares without division
  assign flags.ovAbove    = (fbX * XW'(4))  >  (refX * XW'(5));   // > 125%
  assign flags.ovBelowRel = (fbX * XW'(5))  <  (refX * XW'(6));   // < 120%
  assign flags.uvBelow    = (fbX * XW'(5))  <  (refX * XW'(3));   // < 60%
  assign flags.uvRecov    = (fbX * XW'(20)) >= (refX * XW'(13));  // >= 65%

  logic [2:0] doneVec;
  logic [2:0] enVec, clrVec;
  assign enVec  = {strobes.hicCntEn,  strobes.uvCntEn,  strobes.ovCntEn};
  assign clrVec = {strobes.hicCntClr, strobes.uvCntClr, strobes.ovCntClr};

  for (genvar g = 0; g < 3; g++) begin : g_timer
    localparam int LIM = (g == 0) ? OV_CONFIRM : ((g == 1) ? UV_CONFIRM : HICCUP_LEN);
    fault_guard_cnt #(.LIMIT(LIM)) cnt_i (
      .clk  (clk),
      .rstN (rstN),
      .en   (enVec[g]),
      .clr  (clrVec[g]),
      .done (doneVec[g])
    );
  end

  assign flags.ovDone  = doneVec[0];
  assign flags.uvDone  = doneVec[1];
  assign flags.hicDone = doneVec[2];
endmodule

// File: rtl/fault_guard_ctrl.sv
module fault_guard_ctrl
  import fault_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       thermTrip,
  input  logic       valleyOc,
  input  logic       ssBusy,
  input  flag_t      flags,
  output strobe_t    strobes,
  output logic       switchesOff,
  output logic       restartReq,
  output logic       holdLowSide,
  output logic [3:0] statusBits
);
  guard_state_t state;
  logic ovFault, uvPend, otReg, ocReg;
  logic inRun;

  assign inRun = (state == ST_RUN);

  always_comb begin
    strobes.ovCntEn   = flags.ovAbove & ~ovFault;
    strobes.ovCntClr  = ~strobes.ovCntEn;
    strobes.uvCntEn   = inRun & ~ssBusy & (flags.uvBelow | (uvPend & ~flags.uvRecov));
    strobes.uvCntClr  = ~strobes.uvCntEn;
    strobes.hicCntEn  = ~inRun;
    strobes.hicCntClr = inRun;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RUN;
      ovFault    <= 1'b0;
      uvPend     <= 1'b0;
      otReg      <= 1'b0;
      ocReg      <= 1'b0;
      restartReq <= 1'b0;
    end else begin
      otReg      <= thermTrip;
      ocReg      <= valleyOc;
      uvPend     <= strobes.uvCntEn;
      restartReq <= 1'b0;

      if (!ovFault && strobes.ovCntEn && flags.ovDone) ovFault <= 1'b1;
      else if (ovFault && flags.ovBelowRel)            ovFault <= 1'b0;

      case (state)
        ST_RUN:
          if (strobes.uvCntEn && flags.uvDone) state <= ST_HICCUP;
        ST_HICCUP:
          if (flags.hicDone) begin
            state      <= ST_RUN;
            restartReq <= 1'b1;
          end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    statusBits          = '0;
    statusBits[STAT_OV] = ovFault;
    statusBits[STAT_UV] = ~inRun;
    statusBits[STAT_OT] = otReg;
    statusBits[STAT_OC] = ocReg;
  end

  assign switchesOff = ovFault | ~inRun | otReg;
  assign holdLowSide = ocReg & ~switchesOff;
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fault_guard_pkg::*;
#(
  parameter int FB_W           = 10,
  parameter int OV_CONFIRM     = 32,
  parameter int UV_CONFIRM     = 256,
  parameter int SS_CYCLES      = 64,
  parameter int HICCUP_PERIODS = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [FB_W-1:0] fbCode,
  input  logic [FB_W-1:0] refCode,
  input  logic            thermTrip,
  input  logic            valleyOc,
  input  logic            ssBusy,
  output logic            switchesOff,
  output logic            restartReq,
  output logic            holdLowSide,
  output logic [3:0]      statusBits
);
  localparam int HICCUP_LEN = HICCUP_PERIODS * SS_CYCLES;

  strobe_t strobes;
  flag_t   flags;

  fault_guard_dp #(
    .FB_W       (FB_W),
    .OV_CONFIRM (OV_CONFIRM),
    .UV_CONFIRM (UV_CONFIRM),
    .HICCUP_LEN (HICCUP_LEN)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .fbCode  (fbCode),
    .refCode (refCode),
    .strobes (strobes),
    .flags   (flags)
  );

  fault_guard_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .thermTrip   (thermTrip),
    .valleyOc    (valleyOc),
    .ssBusy      (ssBusy),
    .flags       (flags),
    .strobes     (strobes),
    .switchesOff (switchesOff),
    .restartReq  (restartReq),
    .holdLowSide (holdLowSide),
    .statusBits  (statusBits)
  );
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       thermTrip,
  input logic       valleyOc,
  input logic       ssBusy,
  input logic       switchesOff,
  input logic       restartReq,
  input logic       holdLowSide,
  input logic [3:0] statusBits
);
  assert_ot_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    thermTrip |=> statusBits[2]);

  assert_off_on_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[0] | statusBits[1] | statusBits[2]) |-> switchesOff);

  assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !restartReq);

  assert_restart_ends_uv_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restartReq) |-> ($past(statusBits[1]) && !statusBits[1]));

  assert_uv_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[1]) |-> !$past(ssBusy));

  assert_hold_from_oc_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdLowSide |-> ($past(valleyOc) && !switchesOff));
endmodule

bind fault_guard fault_guard_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .thermTrip   (thermTrip),
  .valleyOc    (valleyOc),
  .ssBusy      (ssBusy),
  .switchesOff (switchesOff),
  .restartReq  (restartReq),
  .holdLowSide (holdLowSide),
  .statusBits  (statusBits)
);

// File: tb/fault_guard_tb_top.sv
module fault_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FB_W       = 10;
  localparam int OVC        = 32;
  localparam int UVC        = 256;
  localparam int SSC        = 64;
  localparam int HIC        = 7 * SSC;
  localparam int REFV       = 400;  // 60%=240, 65%=260, 120%=480, 125%=500

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [FB_W-1:0] fbCode = FB_W'(REFV);
  logic [FB_W-1:0] refCode = FB_W'(REFV);
  logic thermTrip = 1'b0, valleyOc = 1'b0, ssBusy = 1'b0;
  logic switchesOff, restartReq, holdLowSide;
  logic [3:0] statusBits;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_guard #(.FB_W(FB_W), .OV_CONFIRM(OVC), .UV_CONFIRM(UVC),
                .SS_CYCLES(SSC), .HICCUP_PERIODS(7)) dut_i (
    .clk(clk), .rstN(rstN), .fbCode(fbCode), .refCode(refCode),
    .thermTrip(thermTrip), .valleyOc(valleyOc), .ssBusy(ssBusy),
    .switchesOff(switchesOff), .restartReq(restartReq),
    .holdLowSide(holdLowSide), .statusBits(statusBits));

  typedef struct packed {
    logic [9:0] fb;
    logic       th;
    logic       oc;
    logic [7:0] cyc;
    logic [3:0] expStat;
    logic       expOff;
    logic       expHold;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{10'd400, 1'b0, 1'b0, 8'd5,  4'h0, 1'b0, 1'b0, 4'd9}, // R9 idle
    '{10'd400, 1'b0, 1'b1, 8'd3,  4'h8, 1'b0, 1'b1, 4'd6}, // R6 hold low side
    '{10'd400, 1'b1, 1'b0, 8'd2,  4'h4, 1'b1, 1'b0, 4'd5}, // R5 thermal off
    '{10'd400, 1'b1, 1'b1, 8'd2,  4'hC, 1'b1, 1'b0, 4'd7}, // R7 both, hold gated
    '{10'd400, 1'b0, 1'b0, 8'd1,  4'h0, 1'b0, 1'b0, 4'd5}, // R5 non-latching
    '{10'd501, 1'b0, 1'b0, 8'd31, 4'h0, 1'b0, 1'b0, 4'd1}, // R1 one short
    '{10'd501, 1'b0, 1'b0, 8'd1,  4'h1, 1'b1, 1'b0, 4'd1}, // R1 trip
    '{10'd481, 1'b0, 1'b0, 8'd5,  4'h1, 1'b1, 1'b0, 4'd2}, // R2 held in band
    '{10'd480, 1'b0, 1'b0, 8'd2,  4'h1, 1'b1, 1'b0, 4'd2}, // R2 exactly 120% held
    '{10'd479, 1'b0, 1'b0, 8'd1,  4'h0, 1'b0, 1'b0, 4'd2}, // R2 release
    '{10'd500, 1'b0, 1'b0, 8'd40, 4'h0, 1'b0, 1'b0, 4'd1}, // R1 exactly 125% no trip
    '{10'd501, 1'b0, 1'b0, 8'd20, 4'h0, 1'b0, 1'b0, 4'd1}, // R1 partial run
    '{10'd400, 1'b0, 1'b0, 8'd1,  4'h0, 1'b0, 1'b0, 4'd1}, // R1 break
    '{10'd501, 1'b0, 1'b0, 8'd31, 4'h0, 1'b0, 1'b0, 4'd1}, // R1 count restarted
    '{10'd501, 1'b1, 1'b1, 8'd1,  4'hD, 1'b1, 1'b0, 4'd7}, // R7 three faults
    '{10'd400, 1'b0, 1'b0, 8'd1,  4'h0, 1'b0, 1'b0, 4'd7}  // R7 all clear
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input logic [3:0] st, input logic off,
                        input logic hold, input logic rs);
    chk(statusBits == st, req, int'(statusBits), int'(st));
    chk(switchesOff == off, req, int'(switchesOff), int'(off));
    chk(holdLowSide == hold, req, int'(holdLowSide), int'(hold));
    chk(restartReq == rs, req, int'(restartReq), int'(rs));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    fbCode = FB_W'(REFV); thermTrip = 0; valleyOc = 0; ssBusy = 0;
    step(2);
    chkOut("R9 reset", 4'h0, 0, 0, 0);
    rstN = 1'b1;
    step(1);
    chkOut("R9 after reset", 4'h0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    for (int i = 0; i < NV; i++) begin
      fbCode    = TBL[i].fb;
      thermTrip = TBL[i].th;
      valleyOc  = TBL[i].oc;
      step(int'(TBL[i].cyc));
      chkOut($sformatf("R%0d row %0d", TBL[i].req, i),
             TBL[i].expStat, TBL[i].expOff, TBL[i].expHold, 1'b0);
    end

    // R3 and R4: plain under-voltage trip and hiccup timing
    doReset();
    fbCode = 10'd239;
    step(UVC - 1);
    chkOut("R3 uv one short", 4'h0, 0, 0, 0);
    step(1);
    chkOut("R3 uv trip", 4'h2, 1, 0, 0);
    step(HIC - 1);
    chkOut("R4 hiccup held", 4'h2, 1, 0, 0);
    step(1);
    chkOut("R4 restart pulse", 4'h0, 0, 0, 1);
    // R8: soft start running with feedback still low
    ssBusy = 1'b1;
    step(1);
    chkOut("R4 pulse ends", 4'h0, 0, 0, 0);
    step(UVC + 50);
    chkOut("R8 masked during soft start", 4'h0, 0, 0, 0);
    // R8: count cleared by soft start, so a fresh full window is needed
    ssBusy = 1'b0;
    step(UVC - 1);
    chkOut("R8 fresh window short", 4'h0, 0, 0, 0);
    step(1);
    chkOut("R8 fresh window trip", 4'h2, 1, 0, 0);

    // R3: band 60..65% keeps counting
    doReset();
    fbCode = 10'd239;
    step(100);
    fbCode = 10'd259;
    step(UVC - 101);
    chkOut("R3 band continues", 4'h0, 0, 0, 0);
    step(1);
    chkOut("R3 band trip", 4'h2, 1, 0, 0);

    // R3: reaching 65% restarts the count
    doReset();
    fbCode = 10'd239;
    step(100);
    fbCode = 10'd260;
    step(1);
    fbCode = 10'd239;
    step(UVC - 1);
    chkOut("R3 count restarted", 4'h0, 0, 0, 0);
    step(1);
    chkOut("R3 trip after restart", 4'h2, 1, 0, 0);

    // R7: thermal during hiccup reported separately
    thermTrip = 1'b1; valleyOc = 1'b1;
    step(1);
    chkOut("R7 uv+ot+oc", 4'hE, 1, 0, 0);

    // R9: reset mid-fault
    doReset();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule